// File: doc/BRIEF.md
# Row Common-Mode and Zero-Suppression Pipeline

This block cleans one detector row at a time. All channels of a row arrive together in one cycle as 8-bit codes, along with the row number. The block first works out the row's common-mode level as the integer mean of every sample in the row. It subtracts that level from each sample, then subtracts the channel's own pedestal, and keeps only the channels whose result is strictly above a programmable threshold.

Surviving pixels leave on a valid/ready stream, one per cycle, in rising column order. Each pixel carries its row, column and corrected value. The last beat of each row is flagged. A row with no survivors still produces one flagged beat, so the consumer always sees a row boundary.

Pedestals are held in a small per-channel store, loaded through a simple write port. That port only accepts writes while no row is in flight and the block is not in test mode. In test mode the data path runs as normal but the stored pedestals are left untouched. The channel count must be a power of two, because the mean is taken with a right shift. With the default eight channels, a full row completes well inside the 80 ns row period.

Top module: `row_zs_pipe`

## Requirements
- R1: After reset, `hit_valid` is 0, `in_ready` is 1 and every stored pedestal is 0.
- R2: The common-mode level is floor(sum of the row's NCH samples / NCH). It is subtracted from each sample first, and a negative difference becomes 0.
- R3: The channel's stored pedestal is then subtracted from that difference, and a negative result becomes 0. This result is the value reported in `hit_val`.
- R4: A channel produces a pixel beat only when its corrected value is strictly greater than `thresh` as sampled with the row. A value equal to `thresh` is dropped.
- R5: Pixel beats of one row leave in ascending column order, one per handshake. Each carries the row index given with the row, and has `hit_pix`=1.
- R6: The final beat of every row has `hit_eor`=1, and no other beat does. A row with no surviving pixel yields exactly one beat, with `hit_pix`=0, `hit_eor`=1, `hit_col`=0 and `hit_val`=0.
- R7: While `hit_valid`=1 and `hit_ready`=0, the output beat stays unchanged in the next cycle.
- R8: `in_ready` falls on the edge that accepts a row and stays 0 until the row's final beat has been taken. A `row_valid` seen while `in_ready`=0 is ignored and produces no beats.
- R9: A pedestal write presented while `in_ready`=0 is ignored.
- R10: A pedestal write presented while `test_mode`=1 is ignored. Rows are still processed normally in that mode.
- R11: With `hit_ready` held at 1, `hit_valid` rises on the third rising edge after the edge that accepts a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_valid | input | 1 | A row is presented this cycle |
| row_idx | input | RW | Row number of the presented row |
| row_samples | input | NCH*PW | Samples, channel c at bits [c*PW +: PW] |
| thresh | input | PW | Suppression threshold, sampled with the row |
| in_ready | output | 1 | Block is idle and will take a row |
| test_mode | input | 1 | Process rows but freeze the pedestal store |
| ped_we | input | 1 | Pedestal write strobe |
| ped_col | input | CW | Channel whose pedestal is written |
| ped_val | input | PW | Pedestal value to store |
| hit_valid | output | 1 | Output beat valid |
| hit_ready | input | 1 | Consumer takes the beat |
| hit_row | output | RW | Row of the beat |
| hit_col | output | CW | Column of the pixel |
| hit_val | output | PW | Corrected value of the pixel |
| hit_pix | output | 1 | Beat carries a pixel (0 on an empty-row marker) |
| hit_eor | output | 1 | Last beat of the row |

## Verification
Flat rows, where every sample equals the mean, must collapse to an empty-row marker. This separates correct common-mode removal from a plain threshold. Ramps and a single hot channel shift the mean enough that only a mean-first, clamp-at-zero order gives the expected survivors. Rows with per-channel pedestals and values sitting exactly at the threshold separate the pedestal stage and the strict comparison. Random rows under random back-pressure, with writes attempted while busy or in test mode, expose ordering, hold and write-blocking faults through the values that later rows carry.

// File: rtl/rzs_pkg.sv
package rzs_pkg;

  localparam int DEF_NCH = 8;
  localparam int DEF_PW  = 8;
  localparam int DEF_RW  = 11;

  // width of an index over n items, never below one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  typedef enum logic [1:0] {
    EM_IDLE = 2'd0,
    EM_SCAN = 2'd1
  } emit_state_t;

endpackage

// File: rtl/rzs_cm_mean.sv
module rzs_cm_mean #(
  parameter int NCH = 8,
  parameter int PW  = 8
) (
  input  logic [NCH*PW-1:0] samples,
  output logic [PW-1:0]     mean
);
  localparam int LOG = (NCH > 1) ? $clog2(NCH) : 0;
  localparam int SW  = PW + LOG;

  logic [SW-1:0] acc [NCH];

  // in-place pairwise adder tree, one level per pass
  always_comb begin
    for (int j = 0; j < NCH; j++) acc[j] = SW'(samples[j*PW +: PW]);
    for (int l = 0; l < LOG; l++) begin
      for (int j = 0; j < (NCH >> (l + 1)); j++) begin
        acc[j] = acc[2*j] + acc[2*j+1];
      end
    end
    mean = PW'(acc[0] >> LOG);
  end

endmodule

// File: rtl/rzs_correct.sv
module rzs_correct #(
  parameter int NCH = 8,
  parameter int PW  = 8
) (
  input  logic [NCH*PW-1:0] samples,
  input  logic [PW-1:0]     cm,
  input  logic [NCH*PW-1:0] peds,
  input  logic [PW-1:0]     thr,
  output logic [NCH*PW-1:0] vals,
  output logic [NCH-1:0]    mask
);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [PW-1:0] smp, ped, d1, d2;
    assign smp = samples[i*PW +: PW];
    assign ped = peds[i*PW +: PW];
    assign d1  = (smp > cm)  ? smp - cm  : '0;
    assign d2  = (d1  > ped) ? d1  - ped : '0;
    assign vals[i*PW +: PW] = d2;
    assign mask[i] = (d2 > thr);
  end

endmodule

// File: rtl/rzs_ped_mem.sv
module rzs_ped_mem #(
  parameter int NCH = 8,
  parameter int PW  = 8,
  parameter int CW  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CW-1:0]     waddr,
  input  logic [PW-1:0]     wdata,
  output logic [NCH*PW-1:0] rd_all
);

  logic [PW-1:0] store [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) store[i] <= '0;
    end else if (we && (32'(waddr) < NCH)) begin
      store[waddr] <= wdata;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_rd
    assign rd_all[i*PW +: PW] = store[i];
  end

endmodule

// File: rtl/rzs_hit_emit.sv
module rzs_hit_emit
  import rzs_pkg::*;
#(
  parameter int NCH = 8,
  parameter int PW  = 8,
  parameter int RW  = 11,
  parameter int CW  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [NCH-1:0]    load_mask,
  input  logic [NCH*PW-1:0] load_vals,
  input  logic [RW-1:0]     load_row,
  input  logic [PW-1:0]     load_thr,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RW-1:0]     out_row,
  output logic [CW-1:0]     out_col,
  output logic [PW-1:0]     out_val,
  output logic              out_pix,
  output logic              out_eor
);

  emit_state_t       st_q;
  logic [NCH-1:0]    mask_q;
  logic [NCH*PW-1:0] vals_q;
  logic [RW-1:0]     row_q;
  logic [PW-1:0]     thr_q;
  logic [CW-1:0]     pick;
  logic [NCH-1:0]    rest;
  logic              found;
  logic              advance;

  // lowest pending column wins
  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask_q[i]) pick = CW'(i);
    end
    found   = |mask_q;
    rest    = mask_q & ~(NCH'(1) << pick);
    advance = (st_q == EM_SCAN) && (!out_valid || out_ready);
  end

  assign busy = (st_q == EM_SCAN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= EM_IDLE;
      mask_q    <= '0;
      vals_q    <= '0;
      row_q     <= '0;
      thr_q     <= '0;
      out_valid <= 1'b0;
      out_row   <= '0;
      out_col   <= '0;
      out_val   <= '0;
      out_pix   <= 1'b0;
      out_eor   <= 1'b0;
    end else if (load) begin
      st_q   <= EM_SCAN;
      mask_q <= load_mask;
      vals_q <= load_vals;
      row_q  <= load_row;
      thr_q  <= load_thr;
    end else if (advance) begin
      out_valid <= 1'b1;
      out_row   <= row_q;
      if (found) begin
        out_col <= pick;
        out_val <= vals_q[pick*PW +: PW];
        out_pix <= 1'b1;
        out_eor <= (rest == '0);
        mask_q  <= rest;
        if (rest == '0) st_q <= EM_IDLE;
      end else begin
        out_col <= '0;
        out_val <= '0;
        out_pix <= 1'b0;
        out_eor <= 1'b1;
        st_q    <= EM_IDLE;
      end
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // checker state: last column handed over within the current row
  logic [CW-1:0] last_col_q;
  logic          in_row_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      last_col_q <= '0;
      in_row_q   <= 1'b0;
    end else if (out_valid && out_ready) begin
      last_col_q <= out_col;
      in_row_q   <= !out_eor;
    end
  end

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable({out_row, out_col, out_val, out_pix, out_eor}))); // R7

  AST_ABOVE_THR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_pix) |-> (out_val > thr_q)); // R4

  AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_pix && in_row_q) |-> (out_col > last_col_q)); // R5

  AST_EMPTY_IS_EOR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_pix) |-> (out_eor && !in_row_q)); // R6

  AST_EOR_ENDS_ROW: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_eor) |=> !out_valid); // R6

endmodule

// File: rtl/row_zs_pipe.sv
module row_zs_pipe
  import rzs_pkg::*;
#(
  parameter int NCH = DEF_NCH,
  parameter int PW  = DEF_PW,
  parameter int RW  = DEF_RW,
  localparam int CW = idx_w(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              row_valid,
  input  logic [RW-1:0]     row_idx,
  input  logic [NCH*PW-1:0] row_samples,
  input  logic [PW-1:0]     thresh,
  output logic              in_ready,
  input  logic              test_mode,
  input  logic              ped_we,
  input  logic [CW-1:0]     ped_col,
  input  logic [PW-1:0]     ped_val,
  output logic              hit_valid,
  input  logic              hit_ready,
  output logic [RW-1:0]     hit_row,
  output logic [CW-1:0]     hit_col,
  output logic [PW-1:0]     hit_val,
  output logic              hit_pix,
  output logic              hit_eor
);

  // stage 1: captured row
  logic              s1_v;
  logic [RW-1:0]     s1_row;
  logic [NCH*PW-1:0] s1_smp;
  logic [PW-1:0]     s1_thr;
  // stage 2: row plus its common-mode level
  logic              s2_v;
  logic [RW-1:0]     s2_row;
  logic [NCH*PW-1:0] s2_smp;
  logic [PW-1:0]     s2_thr;
  logic [PW-1:0]     s2_cm;

  logic [PW-1:0]     mean_c;
  logic [NCH*PW-1:0] peds;
  logic [NCH*PW-1:0] corr_vals;
  logic [NCH-1:0]    corr_mask;
  logic              emit_busy;
  logic              accept;
  logic              ped_wr_ok;

  assign in_ready  = !(s1_v || s2_v || emit_busy || hit_valid);
  assign accept    = row_valid && in_ready;
  assign ped_wr_ok = ped_we && in_ready && !test_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else begin
      s1_v <= accept;
      s2_v <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_row <= row_idx;
      s1_smp <= row_samples;
      s1_thr <= thresh;
    end
    if (s1_v) begin
      s2_row <= s1_row;
      s2_smp <= s1_smp;
      s2_thr <= s1_thr;
      s2_cm  <= mean_c;
    end
  end

  rzs_cm_mean #(.NCH(NCH), .PW(PW)) u_mean (
    .samples (s1_smp),
    .mean    (mean_c)
  );

  rzs_ped_mem #(.NCH(NCH), .PW(PW), .CW(CW)) u_ped (
    .clk    (clk),
    .rst    (rst),
    .we     (ped_wr_ok),
    .waddr  (ped_col),
    .wdata  (ped_val),
    .rd_all (peds)
  );

  rzs_correct #(.NCH(NCH), .PW(PW)) u_corr (
    .samples (s2_smp),
    .cm      (s2_cm),
    .peds    (peds),
    .thr     (s2_thr),
    .vals    (corr_vals),
    .mask    (corr_mask)
  );

  rzs_hit_emit #(.NCH(NCH), .PW(PW), .RW(RW), .CW(CW)) u_emit (
    .clk       (clk),
    .rst       (rst),
    .load      (s2_v),
    .load_mask (corr_mask),
    .load_vals (corr_vals),
    .load_row  (s2_row),
    .load_thr  (s2_thr),
    .busy      (emit_busy),
    .out_valid (hit_valid),
    .out_ready (hit_ready),
    .out_row   (hit_row),
    .out_col   (hit_col),
    .out_val   (hit_val),
    .out_pix   (hit_pix),
    .out_eor   (hit_eor)
  );

  AST_PED_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!in_ready || test_mode) |=> $stable(peds)); // R9

  AST_NOT_READY_WHILE_OUT: assert property (@(posedge clk) disable iff (rst)
    hit_valid |-> !in_ready); // R8

  AST_LOAD_FROM_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    s2_v |-> $past(accept, 2)); // R11

endmodule

// File: tb/row_zs_pipe_bench.sv
module row_zs_pipe_bench;
  localparam int NCH = 8;
  localparam int PW  = 8;
  localparam int RW  = 11;
  localparam int CW  = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              row_valid = 1'b0;
  logic [RW-1:0]     row_idx = '0;
  logic [NCH*PW-1:0] row_samples = '0;
  logic [PW-1:0]     thresh = '0;
  logic              in_ready;
  logic              test_mode = 1'b0;
  logic              ped_we = 1'b0;
  logic [CW-1:0]     ped_col = '0;
  logic [PW-1:0]     ped_val = '0;
  logic              hit_valid;
  logic              hit_ready = 1'b1;
  logic [RW-1:0]     hit_row;
  logic [CW-1:0]     hit_col;
  logic [PW-1:0]     hit_val;
  logic              hit_pix;
  logic              hit_eor;

  always #10 clk = ~clk;

  row_zs_pipe #(.NCH(NCH), .PW(PW), .RW(RW)) u_row_zs_pipe (
    .clk(clk), .rst(rst), .row_valid(row_valid), .row_idx(row_idx),
    .row_samples(row_samples), .thresh(thresh), .in_ready(in_ready),
    .test_mode(test_mode), .ped_we(ped_we), .ped_col(ped_col), .ped_val(ped_val),
    .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_row(hit_row),
    .hit_col(hit_col), .hit_val(hit_val), .hit_pix(hit_pix), .hit_eor(hit_eor)
  );

  int checks = 0;
  int errors = 0;
  int ped_m [NCH];
  int q_row[$], q_col[$], q_val[$], q_pix[$], q_eor[$];
  bit busy_m = 0;
  bit stall_en = 0;
  int extra = 0;
  int seed = 32'h1234_5678;

  function automatic int rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >>> 17);
    seed = seed ^ (seed << 5);
    return seed & 32'h7fff_ffff;
  endfunction

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  // reference: mean first, then pedestal, clamp at zero, strict threshold
  task automatic model_row(input int r, input logic [NCH*PW-1:0] d, input int thr);
    int s[NCH];
    int sum = 0;
    int cm, nh = 0;
    for (int c = 0; c < NCH; c++) begin
      s[c] = int'(d[c*PW +: PW]);
      sum += s[c];
    end
    cm = sum / NCH;
    for (int c = 0; c < NCH; c++) begin
      int a = s[c] - cm;
      int b;
      if (a < 0) a = 0;
      b = a - ped_m[c];
      if (b < 0) b = 0;
      if (b > thr) begin
        q_row.push_back(r); q_col.push_back(c); q_val.push_back(b);
        q_pix.push_back(1); q_eor.push_back(0);
        nh++;
      end
    end
    if (nh == 0) begin
      q_row.push_back(r); q_col.push_back(0); q_val.push_back(0);
      q_pix.push_back(0); q_eor.push_back(1);
    end else begin
      q_eor[q_eor.size()-1] = 1;
    end
  endtask

  // back-pressure driver
  always @(posedge clk) begin
    #1;
    hit_ready = stall_en ? rnd()[0] : 1'b1;
  end

  // monitor: compare each beat at its handshake, and holds under stall
  bit held_v = 0;
  logic [RW-1:0] h_row; logic [CW-1:0] h_col; logic [PW-1:0] h_val; logic h_pix, h_eor;
  always @(negedge clk) begin
    if (!rst) begin
      if (held_v) begin
        chk(hit_valid && hit_row == h_row && hit_col == h_col && hit_val == h_val &&
            hit_pix == h_pix && hit_eor == h_eor,
            $sformatf("R7 held beat changed: got v%0d col %0d val %0d, expected col %0d val %0d",
                      hit_valid, hit_col, hit_val, h_col, h_val));
      end
      held_v = 0;
      if (hit_valid) begin
        if (!hit_ready) begin
          held_v = 1;
          h_row = hit_row; h_col = hit_col; h_val = hit_val; h_pix = hit_pix; h_eor = hit_eor;
        end else if (q_col.size() == 0) begin
          extra++;
          chk(0, $sformatf("R8 unexpected beat: got row %0d col %0d, expected none", hit_row, hit_col));
        end else begin
          // R2 R3 R4 R5 R6: value, order and framing of every beat
          chk(int'(hit_row) == q_row[0] && int'(hit_col) == q_col[0] && int'(hit_val) == q_val[0] &&
              int'(hit_pix) == q_pix[0] && int'(hit_eor) == q_eor[0],
              $sformatf("R5/R6 beat: got row %0d col %0d val %0d pix %0d eor %0d, expected row %0d col %0d val %0d pix %0d eor %0d",
                        hit_row, hit_col, hit_val, hit_pix, hit_eor,
                        q_row[0], q_col[0], q_val[0], q_pix[0], q_eor[0]));
          if (q_eor[0] == 1) busy_m = 0;
          void'(q_row.pop_front()); void'(q_col.pop_front()); void'(q_val.pop_front());
          void'(q_pix.pop_front()); void'(q_eor.pop_front());
        end
      end
    end
  end

  task automatic send_row(input int r, input logic [NCH*PW-1:0] d, input bit lat);
    do @(negedge clk); while (!in_ready);
    row_valid = 1'b1; row_idx = RW'(r); row_samples = d;
    @(posedge clk);
    model_row(r, d, int'(thresh));
    busy_m = 1;
    #1 row_valid = 1'b0;
    if (lat) begin
      repeat (3) @(negedge clk);
      chk(hit_valid == 1'b0, $sformatf("R11 valid too early: got %0d, expected 0", hit_valid));
      @(negedge clk);
      chk(hit_valid == 1'b1, $sformatf("R11 valid late: got %0d, expected 1", hit_valid));
    end
  endtask

  task automatic wr_ped(input int c, input int v);
    @(negedge clk);
    ped_we = 1'b1; ped_col = CW'(c); ped_val = PW'(v);
    if (!busy_m && !test_mode) ped_m[c] = v;
    @(posedge clk);
    #1 ped_we = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(in_ready && q_col.size() == 0));
  endtask

  function automatic logic [NCH*PW-1:0] pack(input int a0, a1, a2, a3, a4, a5, a6, a7);
    return {PW'(a7), PW'(a6), PW'(a5), PW'(a4), PW'(a3), PW'(a2), PW'(a1), PW'(a0)};
  endfunction

  bit done = 0;

  initial begin
    for (int c = 0; c < NCH; c++) ped_m[c] = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset, pedestals zero (seen through the next row)
    chk(hit_valid == 1'b0, $sformatf("R1 hit_valid after reset: got %0d, expected 0", hit_valid));
    chk(in_ready == 1'b1, $sformatf("R1 in_ready after reset: got %0d, expected 1", in_ready));

    // R6 flat row collapses to an empty marker; R11 latency
    thresh = 8'd0;
    send_row(1, pack(50, 50, 50, 50, 50, 50, 50, 50), 1'b1);
    wait_idle();
    // R2 ramp: mean 35 removed before the threshold
    thresh = 8'd5;
    send_row(2, pack(0, 10, 20, 30, 40, 50, 60, 70), 1'b0);
    // R2 single hot channel: mean 31
    thresh = 8'd0;
    send_row(3, pack(0, 0, 0, 0, 0, 255, 0, 0), 1'b0);
    wait_idle();
    // R3 per-channel pedestals
    for (int c = 0; c < NCH; c++) wr_ped(c, 3 * c);
    send_row(4, pack(10, 90, 20, 80, 30, 70, 40, 60), 1'b0);
    wait_idle();
    // R4 value equal to threshold is dropped: corrected 20 at thr 20, 21 passes
    for (int c = 0; c < NCH; c++) wr_ped(c, 0);
    thresh = 8'd20;
    send_row(5, pack(20, 0, 0, 0, 0, 0, 0, 0), 1'b0);    // mean 2 -> 18
    send_row(6, pack(24, 0, 0, 0, 0, 0, 0, 0), 1'b0);    // mean 3 -> 21
    send_row(7, pack(23, 0, 0, 0, 0, 0, 0, 0), 1'b0);    // mean 2 -> 21
    send_row(8, pack(22, 0, 0, 0, 0, 0, 0, 0), 1'b0);    // mean 2 -> 20, dropped
    wait_idle();

    // R8: second row offered while busy is ignored
    thresh = 8'd0;
    send_row(9, pack(1, 2, 3, 4, 5, 6, 7, 100), 1'b0);
    @(negedge clk);
    chk(in_ready == 1'b0, $sformatf("R8 in_ready while busy: got %0d, expected 0", in_ready));
    row_valid = 1'b1; row_idx = 11'd77; row_samples = pack(200, 0, 0, 0, 0, 0, 0, 0);
    @(posedge clk); #1 row_valid = 1'b0;
    // R9: pedestal write while busy is ignored
    wr_ped(7, 90);
    wait_idle();
    repeat (10) @(negedge clk);
    chk(extra == 0 && q_col.size() == 0, $sformatf("R8 stray beats: got %0d, expected 0", extra));
    send_row(10, pack(0, 0, 0, 0, 0, 0, 0, 120), 1'b0);  // R9 visible: ped 7 still 0
    wait_idle();

    // R10: writes ignored in test mode, rows still processed
    test_mode = 1'b1;
    wr_ped(2, 40);
    send_row(11, pack(0, 0, 100, 0, 0, 0, 0, 0), 1'b0);
    wait_idle();
    test_mode = 1'b0;
    wr_ped(2, 40);
    send_row(12, pack(0, 0, 100, 0, 0, 0, 0, 0), 1'b0);
    wait_idle();

    // R5 R7: random rows, pedestals and thresholds under back-pressure
    stall_en = 1;
    for (int k = 0; k < 40; k++) begin
      logic [NCH*PW-1:0] d;
      if (k % 8 == 0) begin
        wait_idle();
        for (int c = 0; c < NCH; c++) wr_ped(c, rnd() % 24);
        thresh = PW'(rnd() % 16);
      end
      for (int c = 0; c < NCH; c++) d[c*PW +: PW] = PW'(rnd());
      send_row(100 + k, d, 1'b0);
    end
    wait_idle();
    stall_en = 0;
    repeat (5) @(negedge clk);
    chk(q_col.size() == 0, $sformatf("R6 beats missing at end: got %0d left, expected 0", q_col.size()));
    chk(in_ready == 1'b1, $sformatf("R8 in_ready after drain: got %0d, expected 1", in_ready));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: got no completion, expected run to end");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule